// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a small microcontroller-style system between four power modes: run, sleep, stop and standby. The CPU asks for a mode with a one-cycle request. The block then drives the CPU clock gate, the peripheral clock gate, the PLL enable, the internal and external oscillator enables, and a regulator mode code with three values. Analog regulation and oscillator start-up are outside the block: an oscillator-ready input stands in for the latter.

Each mode has its own clock and regulator settings and its own set of wakeup sources. Sleep returns to run on a pending interrupt or on any enabled event. Stop returns on any enabled event line: sixteen external lines, a voltage-detector output, an RTC alarm and a USB wakeup. It then waits for the oscillator before it gates the clocks back on. Standby powers the core domain down, so leaving it does not resume. It issues a system reset request of fixed length and then re-enters run.

The wakeup pin passes through a two-flop synchronizer and a rising-edge detector. An edge that arrives in the same cycle as the standby request is held, so it is not lost.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low and directly after it is released, the block is in run: `cpu_clk_en`, `per_clk_en`, `pll_en`, `hsi_en` and `hse_en` are 1, `reg_mode` is 0 (main), `sys_rst_req` is 0 and `mode_stat` is 0.
- R2: In run, a cycle with `req_valid` high moves the block to the mode in `req_mode` after that clock edge. The encoding is 0 = run, 1 = sleep, 2 = stop, 3 = standby, and `mode_stat` uses the same encoding. A request for run has no effect, and any request made outside run is ignored.
- R3: In sleep only the CPU clock is gated off. Peripheral clocks, PLL and both oscillators stay on and `reg_mode` is 0. On the edge where `irq_pending` is high, or where any event is both asserted and enabled in `evt_mask`, the block returns to run.
- R4: In stop, all five clock and oscillator enables are 0 and `mode_stat` is 2. `reg_mode` is 1 (low-power) if `lp_cfg` was 1 in the request cycle and 0 otherwise. A later change of `lp_cfg` has no effect.
- R5: Stop is left only for an event whose `evt_mask` bit is set. Mask bit order: bits 0..15 are `evt_lines`, bit 16 is `pvd_evt`, bit 17 is `rtc_alarm`, bit 18 is `usb_evt`. Masked events and `irq_pending` do not wake stop.
- R6: After a stop wakeup the block resumes with `reg_mode` 0, `pll_en`, `hsi_en` and `hse_en` at 1, both clock gates at 0 and `mode_stat` still 2. It enters run on the first edge where `osc_ready` is high.
- R7: In standby, `reg_mode` is 2 (power-down, output high impedance), all enables are 0 and `mode_stat` is 3. `irq_pending` and the events in `evt_mask` do not wake it.
- R8: Standby is left on `rtc_alarm`, on `iwdg_rst`, or on a rising edge of `wkup_pin`. A pin rise set up before clock edge k takes effect at edge k+2.
- R9: On leaving standby, `sys_rst_req` is 1 for exactly `RST_CYC` cycles. During that time `reg_mode` is 0, `hsi_en` is 1, all other enables are 0 and `mode_stat` is 3. Run follows.
- R10: A `wkup_pin` rising edge that is detected in the very cycle standby is requested still wakes the block on the following edge.
- R11: Driving `rst_n` low returns the block to the run outputs at once, from any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset (external reset pin) |
| req_valid | input | 1 | One-cycle mode request strobe from the CPU |
| req_mode | input | 2 | Requested mode, 0 run, 1 sleep, 2 stop, 3 standby |
| lp_cfg | input | 1 | Low-power regulator select for stop, sampled at entry |
| irq_pending | input | 1 | Pending interrupt, wakes sleep |
| evt_lines | input | 16 | External event lines |
| pvd_evt | input | 1 | Voltage-detector event |
| rtc_alarm | input | 1 | RTC alarm |
| usb_evt | input | 1 | USB wakeup event |
| evt_mask | input | 19 | Event enables, order given in R5 |
| wkup_pin | input | 1 | Asynchronous wakeup pin |
| iwdg_rst | input | 1 | Independent-watchdog reset request |
| osc_ready | input | 1 | Oscillator ready after stop |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| pll_en | output | 1 | PLL enable |
| hsi_en | output | 1 | Internal oscillator enable |
| hse_en | output | 1 | External oscillator enable |
| reg_mode | output | 2 | Regulator mode, 0 main, 1 low-power, 2 power-down |
| sys_rst_req | output | 1 | System reset request after standby |
| mode_stat | output | 2 | Current mode, encoded as in R2 |

## Verification
All outputs decode from the state register. A request, a sleep or stop wakeup, or an `osc_ready` seen while resuming therefore shows on the outputs just after the one clock edge that samples it. A wakeup-pin rise needs two further edges for the synchronizer and the edge register. The reset request then lasts `RST_CYC` cycles. The bench drives inputs on the falling edge and queues one expected output vector per cycle. A monitor pops and compares each vector 1 ns after the next rising edge, so every expectation lines up with the exact edge at which the result is due.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_STOP  = 2'd2,
    MODE_STBY  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    REG_MAIN = 2'd0,
    REG_LOW  = 2'd1,
    REG_OFF  = 2'd2
  } reg_e;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_STOP   = 3'd2,
    ST_RESUME = 3'd3,
    ST_STBY   = 3'd4,
    ST_WRST   = 3'd5
  } state_e;
endpackage

// File: rtl/lpm_pin_edge.sv
module lpm_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  // R8: a held pin produces a single-cycle pulse
  assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/lpm_wake_gather.sv
module lpm_wake_gather #(
  parameter int NLINES = 16,
  localparam int NEVT = NLINES + 3
) (
  input  logic [NLINES-1:0] evt_lines,
  input  logic              pvd_evt,
  input  logic              rtc_alarm,
  input  logic              usb_evt,
  input  logic [NEVT-1:0]   evt_mask,
  input  logic              irq_pending,
  input  logic              pin_rise,
  input  logic              iwdg_rst,
  output logic              wake_sleep,
  output logic              wake_stop,
  output logic              wake_stby
);
  logic [NEVT-1:0] evt_vec;
  logic            evt_any;

  always_comb begin
    evt_vec    = {usb_evt, rtc_alarm, pvd_evt, evt_lines};
    evt_any    = |(evt_vec & evt_mask);
    wake_sleep = irq_pending | evt_any;
    wake_stop  = evt_any;
    wake_stby  = pin_rise | rtc_alarm | iwdg_rst;
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int RST_CYC = 8,
  localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1,
  localparam int RW = $clog2(RST_CYC + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       lp_cfg,
  input  logic       wake_sleep,
  input  logic       wake_stop,
  input  logic       wake_stby,
  input  logic       pin_rise,
  input  logic       irq_pending,
  input  logic       osc_ready,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       pll_en,
  output logic       hsi_en,
  output logic       hse_en,
  output logic [1:0] reg_mode,
  output logic       sys_rst_req,
  output logic [1:0] mode_stat
);
  state_e        state_q, state_d;
  logic          stop_lp_q, stop_lp_d;
  logic          pin_hold_q, pin_hold_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // next-state process
  always_comb begin
    state_d    = state_q;
    stop_lp_d  = stop_lp_q;
    pin_hold_d = pin_hold_q;
    cnt_d      = cnt_q;
    unique case (state_q)
      ST_RUN: if (req_valid) begin
        unique case (mode_e'(req_mode))
          MODE_SLEEP: state_d = ST_SLEEP;
          MODE_STOP: begin
            state_d   = ST_STOP;
            stop_lp_d = lp_cfg;
          end
          MODE_STBY: begin
            state_d    = ST_STBY;
            pin_hold_d = pin_rise;
          end
          default: state_d = ST_RUN;
        endcase
      end
      ST_SLEEP:  if (wake_sleep) state_d = ST_RUN;
      ST_STOP:   if (wake_stop) state_d = ST_RESUME;
      ST_RESUME: if (osc_ready) state_d = ST_RUN;
      ST_STBY: if (wake_stby || pin_hold_q) begin
        state_d    = ST_WRST;
        pin_hold_d = 1'b0;
        cnt_d      = CW'(RST_CYC - 1);
      end
      ST_WRST: begin
        if (cnt_q == '0) state_d = ST_RUN;
        else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      stop_lp_q  <= 1'b0;
      pin_hold_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      state_q    <= state_d;
      stop_lp_q  <= stop_lp_d;
      pin_hold_q <= pin_hold_d;
      cnt_q      <= cnt_d;
    end
  end

  // output decode
  always_comb begin
    cpu_clk_en  = 1'b0;
    per_clk_en  = 1'b0;
    pll_en      = 1'b0;
    hsi_en      = 1'b0;
    hse_en      = 1'b0;
    reg_mode    = REG_MAIN;
    sys_rst_req = 1'b0;
    mode_stat   = MODE_RUN;
    unique case (state_q)
      ST_RUN: begin
        cpu_clk_en = 1'b1; per_clk_en = 1'b1;
        pll_en = 1'b1; hsi_en = 1'b1; hse_en = 1'b1;
      end
      ST_SLEEP: begin
        per_clk_en = 1'b1;
        pll_en = 1'b1; hsi_en = 1'b1; hse_en = 1'b1;
        mode_stat = MODE_SLEEP;
      end
      ST_STOP: begin
        reg_mode  = stop_lp_q ? REG_LOW : REG_MAIN;
        mode_stat = MODE_STOP;
      end
      ST_RESUME: begin
        pll_en = 1'b1; hsi_en = 1'b1; hse_en = 1'b1;
        mode_stat = MODE_STOP;
      end
      ST_STBY: begin
        reg_mode  = REG_OFF;
        mode_stat = MODE_STBY;
      end
      ST_WRST: begin
        hsi_en      = 1'b1;
        sys_rst_req = 1'b1;
        mode_stat   = MODE_STBY;
      end
      default: ;
    endcase
  end

  // length of the current reset-request run, for the R9 check
  logic [RW-1:0] rst_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_run_q <= '0;
    else if (sys_rst_req) rst_run_q <= rst_run_q + 1'b1;
    else rst_run_q <= '0;
  end

  assert_req_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && !wake_stop) |=> mode_stat == MODE_STOP);

  assert_sleep_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && irq_pending) |=> (cpu_clk_en && mode_stat == MODE_RUN));

  assert_stop_reg_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && !wake_stop) |=> $stable(reg_mode));

  assert_resume_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESUME && !osc_ready) |=> !cpu_clk_en);

  assert_stby_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == MODE_STBY && !sys_rst_req) |-> (!pll_en && !hsi_en && !hse_en));

  assert_rst_len_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_run_q <= RW'(RST_CYC));

  assert_rst_len_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) |-> rst_run_q == RW'(RST_CYC));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NLINES = 16,
  parameter int RST_CYC = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NEVT = NLINES + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              lp_cfg,
  input  logic              irq_pending,
  input  logic [NLINES-1:0] evt_lines,
  input  logic              pvd_evt,
  input  logic              rtc_alarm,
  input  logic              usb_evt,
  input  logic [NEVT-1:0]   evt_mask,
  input  logic              wkup_pin,
  input  logic              iwdg_rst,
  input  logic              osc_ready,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              pll_en,
  output logic              hsi_en,
  output logic              hse_en,
  output logic [1:0]        reg_mode,
  output logic              sys_rst_req,
  output logic [1:0]        mode_stat
);
  logic pin_rise, wake_sleep, wake_stop, wake_stby;

  lpm_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(wkup_pin), .rise(pin_rise)
  );

  lpm_wake_gather #(.NLINES(NLINES)) u_wake (
    .evt_lines(evt_lines), .pvd_evt(pvd_evt), .rtc_alarm(rtc_alarm),
    .usb_evt(usb_evt), .evt_mask(evt_mask), .irq_pending(irq_pending),
    .pin_rise(pin_rise), .iwdg_rst(iwdg_rst),
    .wake_sleep(wake_sleep), .wake_stop(wake_stop), .wake_stby(wake_stby)
  );

  lpm_seq #(.RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .lp_cfg(lp_cfg), .wake_sleep(wake_sleep), .wake_stop(wake_stop),
    .wake_stby(wake_stby), .pin_rise(pin_rise), .irq_pending(irq_pending),
    .osc_ready(osc_ready),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pll_en(pll_en),
    .hsi_en(hsi_en), .hse_en(hse_en), .reg_mode(reg_mode),
    .sys_rst_req(sys_rst_req), .mode_stat(mode_stat)
  );
endmodule

// File: tb/lpm_ctrl_test.sv
`timescale 1ns/1ps
module lpm_ctrl_test;
  localparam int RST = 8;

  logic clk = 1'b0;
  logic rst_n, req_valid, lp_cfg, irq_pending, pvd_evt, rtc_alarm, usb_evt;
  logic wkup_pin, iwdg_rst, osc_ready;
  logic [1:0] req_mode;
  logic [15:0] evt_lines;
  logic [18:0] evt_mask;
  logic cpu_clk_en, per_clk_en, pll_en, hsi_en, hse_en, sys_rst_req;
  logic [1:0] reg_mode, mode_stat;

  int checks = 0;
  int errors = 0;
  logic [9:0] eq[$];
  string      tq[$];

  always #2.5 clk = ~clk;

  lpm_ctrl #(.RST_CYC(RST)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .lp_cfg(lp_cfg), .irq_pending(irq_pending), .evt_lines(evt_lines),
    .pvd_evt(pvd_evt), .rtc_alarm(rtc_alarm), .usb_evt(usb_evt),
    .evt_mask(evt_mask), .wkup_pin(wkup_pin), .iwdg_rst(iwdg_rst),
    .osc_ready(osc_ready), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .pll_en(pll_en), .hsi_en(hsi_en), .hse_en(hse_en), .reg_mode(reg_mode),
    .sys_rst_req(sys_rst_req), .mode_stat(mode_stat)
  );

  // {cpu, per, pll, hsi, hse, reg[1:0], rst, stat[1:0]}
  function automatic logic [9:0] actual();
    return {cpu_clk_en, per_clk_en, pll_en, hsi_en, hse_en, reg_mode, sys_rst_req, mode_stat};
  endfunction
  localparam logic [9:0] E_RUN    = {5'b11111, 2'd0, 1'b0, 2'd0};
  localparam logic [9:0] E_SLEEP  = {5'b01111, 2'd0, 1'b0, 2'd1};
  localparam logic [9:0] E_STOPM  = {5'b00000, 2'd0, 1'b0, 2'd2};
  localparam logic [9:0] E_STOPL  = {5'b00000, 2'd1, 1'b0, 2'd2};
  localparam logic [9:0] E_RESUME = {5'b00111, 2'd0, 1'b0, 2'd2};
  localparam logic [9:0] E_STBY   = {5'b00000, 2'd2, 1'b0, 2'd3};
  localparam logic [9:0] E_WRST   = {5'b00010, 2'd0, 1'b1, 2'd3};

  task automatic compare(input logic [9:0] exp, input string tag);
    checks++;
    if (actual() !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, actual(), exp);
    end
  endtask

  // driver: queue the expectation for the next rising edge, then move on
  task automatic cyc(input logic [9:0] exp, input string tag);
    eq.push_back(exp);
    tq.push_back(tag);
    @(negedge clk);
  endtask

  task automatic clear_pulses();
    req_valid = 1'b0; irq_pending = 1'b0; evt_lines = '0; pvd_evt = 1'b0;
    rtc_alarm = 1'b0; usb_evt = 1'b0; iwdg_rst = 1'b0;
  endtask

  task automatic request(input logic [1:0] m);
    req_valid = 1'b1; req_mode = m;
  endtask

  // monitor: one comparison per cycle, 1 ns after the rising edge
  always begin
    @(posedge clk);
    #1;
    if (eq.size() > 0) compare(eq.pop_front(), tq.pop_front());
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_mode = 2'd0; lp_cfg = 1'b0; evt_mask = '0;
    wkup_pin = 1'b0; osc_ready = 1'b0;
    clear_pulses();
    @(negedge clk);
    cyc(E_RUN, "R1 in reset");
    rst_n = 1'b1;
    cyc(E_RUN, "R1 after release");

    // R2: run request has no effect
    request(2'd0); cyc(E_RUN, "R2 run request");
    clear_pulses();

    // R3 sleep, woken by interrupt
    request(2'd1); cyc(E_SLEEP, "R2 R3 enter sleep");
    clear_pulses(); cyc(E_SLEEP, "R3 stays asleep");
    request(2'd2); cyc(E_SLEEP, "R2 request ignored in sleep");
    clear_pulses(); irq_pending = 1'b1; cyc(E_RUN, "R3 irq wake");
    clear_pulses();

    // R3 sleep, woken by enabled event line 0; masked line 5 ignored
    evt_mask = 19'h00001;
    request(2'd1); cyc(E_SLEEP, "R3 enter sleep");
    clear_pulses(); evt_lines[5] = 1'b1; cyc(E_SLEEP, "R3 masked line");
    clear_pulses(); evt_lines[0] = 1'b1; cyc(E_RUN, "R3 event wake");
    clear_pulses();

    // R4 R5 R6 stop with low-power regulator, RTC alarm wake
    evt_mask = 19'h20000;
    lp_cfg = 1'b1; request(2'd2); cyc(E_STOPL, "R4 enter stop low-power");
    clear_pulses(); lp_cfg = 1'b0; cyc(E_STOPL, "R4 lp_cfg change ignored");
    irq_pending = 1'b1; cyc(E_STOPL, "R5 irq ignored in stop");
    clear_pulses(); evt_lines = 16'hffff; pvd_evt = 1'b1; usb_evt = 1'b1;
    cyc(E_STOPL, "R5 masked events ignored");
    clear_pulses(); request(2'd1); cyc(E_STOPL, "R2 request ignored in stop");
    clear_pulses(); rtc_alarm = 1'b1; cyc(E_RESUME, "R5 R6 rtc wake");
    clear_pulses(); cyc(E_RESUME, "R6 wait oscillator");
    cyc(E_RESUME, "R6 wait oscillator 2");
    osc_ready = 1'b1; cyc(E_RUN, "R6 resume to run");
    osc_ready = 1'b0;

    // R4 R5 stop with main regulator, USB wake
    evt_mask = 19'h40000;
    lp_cfg = 1'b0; request(2'd2); cyc(E_STOPM, "R4 enter stop main");
    clear_pulses(); lp_cfg = 1'b1; cyc(E_STOPM, "R4 lp_cfg ignored");
    usb_evt = 1'b1; cyc(E_RESUME, "R5 usb wake");
    clear_pulses(); osc_ready = 1'b1; cyc(E_RUN, "R6 run");
    osc_ready = 1'b0; lp_cfg = 1'b0;

    // R7 R8 R9 standby, RTC alarm wake
    evt_mask = '1;
    request(2'd3); cyc(E_STBY, "R7 enter standby");
    clear_pulses(); irq_pending = 1'b1; evt_lines = 16'hffff; pvd_evt = 1'b1;
    usb_evt = 1'b1; cyc(E_STBY, "R7 events ignored");
    clear_pulses(); rtc_alarm = 1'b1; cyc(E_WRST, "R8 rtc wake");
    clear_pulses();
    for (int i = 1; i < RST; i++) cyc(E_WRST, "R9 reset request held");
    cyc(E_RUN, "R9 back to run");

    // R8 R9 standby, watchdog wake
    request(2'd3); cyc(E_STBY, "R7 enter standby");
    clear_pulses(); iwdg_rst = 1'b1; cyc(E_WRST, "R8 watchdog wake");
    clear_pulses();
    for (int i = 1; i < RST; i++) cyc(E_WRST, "R9 reset held");
    cyc(E_RUN, "R9 run");

    // R8 standby, wakeup pin edge two edges after the first sampling edge
    request(2'd3); cyc(E_STBY, "R7 enter standby");
    clear_pulses(); wkup_pin = 1'b1; cyc(E_STBY, "R8 pin sync 1");
    cyc(E_STBY, "R8 pin sync 2");
    cyc(E_WRST, "R8 pin wake");
    for (int i = 1; i < RST; i++) cyc(E_WRST, "R9 reset held");
    cyc(E_RUN, "R9 run");
    wkup_pin = 1'b0;
    cyc(E_RUN, "R8 pin low in run"); cyc(E_RUN, "R8 idle"); cyc(E_RUN, "R8 idle");

    // R10 edge coinciding with standby entry
    wkup_pin = 1'b1; cyc(E_RUN, "R10 pin sync 1");
    cyc(E_RUN, "R10 pin sync 2");
    request(2'd3); cyc(E_STBY, "R10 enter with edge");
    clear_pulses(); cyc(E_WRST, "R10 held edge wakes");
    for (int i = 1; i < RST; i++) cyc(E_WRST, "R9 reset held");
    cyc(E_RUN, "R9 run");
    wkup_pin = 1'b0;

    // R11 asynchronous reset from stop
    lp_cfg = 1'b1; request(2'd2); cyc(E_STOPL, "R4 enter stop");
    clear_pulses(); lp_cfg = 1'b0;
    while (eq.size() > 0) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 compare(E_RUN, "R11 async reset");
    @(negedge clk); rst_n = 1'b1;
    cyc(E_RUN, "R11 run after reset");
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule